// File: doc/BRIEF.md
# Fetch Target Predictor with Return Stack

This block produces the address of the next instruction fetch, once per cycle. It holds a direct-mapped table of branch targets, each entry carrying a partial tag, the branch kind and the target. Two PCs that differ only in tag bits above the stored slice alias to the same entry, and this is accepted by design. A lookup that hits on a taken branch redirects fetch to the stored target. Any other lookup falls through to the sequential address, PC plus four.

Branches tagged as calls push their return address (call PC plus four) onto a circular eight-deep return stack when they are predicted taken. Entries tagged as returns ignore their stored target and pop the stack top instead. A separate update port, driven when a branch resolves, writes the tag, kind and target of one entry. That write is seen by lookups from the following cycle onward.

The taken/not-taken direction comes from an external predictor. Repairing the stack after a misprediction is left to surrounding logic.

Top module: `fetch_target_predictor`

## Requirements
- R1: After synchronous reset every table entry is invalid and the return stack is empty, so every lookup misses and `next_pc` equals `fetch_pc + 4`.
- R2: The entry index is `fetch_pc[7:2]` and the stored tag is compared with `fetch_pc[15:8]`. Bits 31:16 are never compared, so PCs that differ only there hit the same entry. A valid entry whose tag differs misses.
- R3: On a hit to an entry of kind other (`upd_kind` 2'b00, or the unused code 2'b11) or kind call (2'b01), `pred_hit` is 1. `next_pc` is the stored target when `pred_taken` is 1 and `fetch_pc + 4` when it is 0. On a miss, `pred_hit` is 0 and `next_pc` is `fetch_pc + 4`.
- R4: When `upd_valid` is 1, the entry at index `upd_pc[7:2]` takes tag `upd_pc[15:8]`, the target and the kind at the clock edge. A lookup in the same cycle still sees the old contents, and lookups from the next cycle on see the new ones.
- R5: A hit to a call entry with `pred_taken` 1 pushes `fetch_pc + 4` onto the return stack. A call hit with `pred_taken` 0 pushes nothing.
- R6: A hit to a return entry (kind 2'b10) while the stack is non-empty sets `pred_hit` and `pred_is_ret` to 1 and drives `next_pc` to the stack top, whatever `pred_taken` is. It then pops that entry, so successive returns see addresses in last-in first-out order.
- R7: A hit to a return entry while the stack is empty gives `pred_is_ret` 1, `pred_hit` 0 and `next_pc` equal to `fetch_pc + 4`, and leaves the stack unchanged.
- R8: The stack holds 8 addresses. A push when it is full overwrites the oldest entry, so after 10 pushes the following pops return the last 8 pushed, newest first, and the ninth pop finds the stack empty.
- R9: A push and a table update in the same cycle both take effect.
- R10: While `fetch_valid` is 0, `pred_hit` and `pred_is_ret` are 0, `next_pc` is `fetch_pc + 4`, and the stack neither pushes nor pops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A lookup is performed this cycle |
| fetch_pc | input | 32 | Address being fetched |
| pred_taken | input | 1 | Direction from the external predictor |
| upd_valid | input | 1 | Write one table entry at the next edge |
| upd_pc | input | 32 | PC of the resolved branch (selects index and tag) |
| upd_target | input | 32 | Resolved target address |
| upd_kind | input | 2 | 00 other, 01 call, 10 return, 11 treated as other |
| next_pc | output | 32 | Predicted next fetch address |
| pred_hit | output | 1 | Lookup produced a redirect-capable prediction |
| pred_is_ret | output | 1 | Lookup hit a return entry |

## Verification
The assertions assume that every input carries a known 0/1 value after reset. They do not assume the update kind is one of the three named codes, and the stimulus deliberately writes the spare code 2'b11. The checker also relies on a call hit and a return hit never coinciding in one lookup, which holds because a single entry carries a single kind. The stimulus drives every input half a cycle away from the active edge. It fills the table through the update port only, so every expected hit traces back to an explicit earlier write. It reaches the full-stack and empty-stack corners through long runs of call and return fetches.

// File: rtl/ftp_pkg.sv
package ftp_pkg;
    localparam int PC_W        = 32;
    localparam int INSTR_BYTES = 4;
    localparam int IDX_LSB     = $clog2(INSTR_BYTES);
    localparam int IDX_W       = 6;
    localparam int ENTRIES     = 1 << IDX_W;
    localparam int TAG_LSB     = IDX_LSB + IDX_W;
    localparam int TAG_W       = 8;
    localparam int RAS_DEPTH   = 8;
    localparam int RAS_CNT_W   = $clog2(RAS_DEPTH + 1);

    typedef enum logic [1:0] {
        BK_OTHER = 2'b00,
        BK_CALL  = 2'b01,
        BK_RET   = 2'b10,
        BK_SPARE = 2'b11
    } br_kind_e;

    typedef logic [PC_W-1:0]  pc_t;
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [TAG_W-1:0] tag_t;

    typedef struct packed {
        logic     valid;
        br_kind_e kind;
        tag_t     tag;
        pc_t      target;
    } entry_t;

    typedef struct packed {
        logic     hit;
        br_kind_e kind;
        pc_t      target;
    } lookup_t;

    function automatic idx_t pc_index(input pc_t pc);
        return pc[IDX_LSB +: IDX_W];
    endfunction

    function automatic tag_t pc_tag(input pc_t pc);
        return pc[TAG_LSB +: TAG_W];
    endfunction

    function automatic pc_t pc_seq(input pc_t pc);
        return pc + pc_t'(INSTR_BYTES);
    endfunction
endpackage

// File: rtl/ftp_table.sv
module ftp_table
    import ftp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pc_t      lk_pc,
    input  logic     wr_en,
    input  pc_t      wr_pc,
    input  pc_t      wr_target,
    input  br_kind_e wr_kind,
    output lookup_t  lk
);
    entry_t tbl_q [ENTRIES];
    entry_t wr_entry;
    idx_t   wr_idx;
    idx_t   lk_idx;
    entry_t lk_entry;

    assign wr_idx = pc_index(wr_pc);
    assign lk_idx = pc_index(lk_pc);

    always_comb begin
        wr_entry        = '0;
        wr_entry.valid  = 1'b1;
        wr_entry.kind   = wr_kind;
        wr_entry.tag    = pc_tag(wr_pc);
        wr_entry.target = wr_target;
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                tbl_q[g] <= '0;
            end else if (wr_en && wr_idx == idx_t'(g)) begin
                tbl_q[g] <= wr_entry;
            end
        end
    end

    always_comb begin
        lk_entry  = tbl_q[lk_idx];
        lk.hit    = lk_entry.valid && (lk_entry.tag == pc_tag(lk_pc));
        lk.kind   = lk_entry.kind;
        lk.target = lk_entry.target;
    end
endmodule

// File: rtl/ftp_ret_stack.sv
module ftp_ret_stack
    import ftp_pkg::*;
#(
    parameter int DEPTH = RAS_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  pc_t  push_addr,
    input  logic pop,
    output pc_t  top_addr,
    output logic empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

    pc_t              slot_q [DEPTH];
    logic [PTR_W-1:0] tos_q;
    logic [PTR_W-1:0] tos_up;
    logic [PTR_W-1:0] tos_dn;
    logic [CNT_W-1:0] count_q;
    logic             full;

    assign tos_up   = (tos_q == LAST_SLOT) ? '0 : tos_q + 1'b1;
    assign tos_dn   = (tos_q == '0) ? LAST_SLOT : tos_q - 1'b1;
    assign empty    = (count_q == '0);
    assign full     = (count_q == FULL_CNT);
    assign top_addr = slot_q[tos_q];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= '0;
            end else if (push && tos_up == PTR_W'(g)) begin
                slot_q[g] <= push_addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tos_q   <= '0;
            count_q <= '0;
        end else if (push) begin
            tos_q <= tos_up;
            if (!full) begin
                count_q <= count_q + 1'b1;
            end
        end else if (pop && !empty) begin
            tos_q   <= tos_dn;
            count_q <= count_q - 1'b1;
        end
    end
endmodule

// File: rtl/ftp_select.sv
module ftp_select
    import ftp_pkg::*;
(
    input  logic    fetch_valid,
    input  pc_t     fetch_pc,
    input  logic    pred_taken,
    input  lookup_t lk,
    input  pc_t     stk_top,
    input  logic    stk_empty,
    output pc_t     next_pc,
    output logic    pred_hit,
    output logic    pred_is_ret,
    output logic    do_push,
    output logic    do_pop
);
    always_comb begin
        next_pc     = pc_seq(fetch_pc);
        pred_hit    = 1'b0;
        pred_is_ret = 1'b0;
        do_push     = 1'b0;
        do_pop      = 1'b0;
        if (fetch_valid && lk.hit) begin
            unique case (lk.kind)
                BK_RET: begin
                    pred_is_ret = 1'b1;
                    if (!stk_empty) begin
                        pred_hit = 1'b1;
                        next_pc  = stk_top;
                        do_pop   = 1'b1;
                    end
                end
                BK_CALL: begin
                    pred_hit = 1'b1;
                    if (pred_taken) begin
                        next_pc = lk.target;
                        do_push = 1'b1;
                    end
                end
                default: begin
                    pred_hit = 1'b1;
                    if (pred_taken) begin
                        next_pc = lk.target;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/fetch_target_predictor.sv
module fetch_target_predictor
    import ftp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fetch_valid,
    input  logic [31:0] fetch_pc,
    input  logic        pred_taken,
    input  logic        upd_valid,
    input  logic [31:0] upd_pc,
    input  logic [31:0] upd_target,
    input  logic [1:0]  upd_kind,
    output logic [31:0] next_pc,
    output logic        pred_hit,
    output logic        pred_is_ret
);
    lookup_t lk;
    pc_t     stk_top;
    logic    stk_empty;
    logic    do_push;
    logic    do_pop;

    ftp_table u_table (
        .clk       (clk),
        .rst       (rst),
        .lk_pc     (fetch_pc),
        .wr_en     (upd_valid),
        .wr_pc     (upd_pc),
        .wr_target (upd_target),
        .wr_kind   (br_kind_e'(upd_kind)),
        .lk        (lk)
    );

    ftp_ret_stack #(.DEPTH(RAS_DEPTH)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (do_push),
        .push_addr (pc_seq(fetch_pc)),
        .pop       (do_pop),
        .top_addr  (stk_top),
        .empty     (stk_empty)
    );

    ftp_select u_select (
        .fetch_valid (fetch_valid),
        .fetch_pc    (fetch_pc),
        .pred_taken  (pred_taken),
        .lk          (lk),
        .stk_top     (stk_top),
        .stk_empty   (stk_empty),
        .next_pc     (next_pc),
        .pred_hit    (pred_hit),
        .pred_is_ret (pred_is_ret),
        .do_push     (do_push),
        .do_pop      (do_pop)
    );
endmodule

// File: rtl/ftp_checker.sv
module ftp_checker
    import ftp_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 fetch_valid,
    input logic [31:0]          fetch_pc,
    input logic [31:0]          next_pc,
    input logic                 pred_hit,
    input logic                 pred_is_ret,
    input logic                 push,
    input logic                 pop,
    input logic                 stk_empty,
    input logic [31:0]          stk_top,
    input logic [RAS_CNT_W-1:0] stk_count
);
    localparam logic [RAS_CNT_W-1:0] FULL_CNT = RAS_CNT_W'(RAS_DEPTH);

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        stk_count <= FULL_CNT); // R8

    AST_MISS_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && !pred_hit) |-> next_pc == fetch_pc + 32'd4); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !fetch_valid |-> (!pred_hit && !pred_is_ret && !push && !pop)); // R10

    AST_EMPTY_RETURN: assert property (@(posedge clk) disable iff (rst)
        (pred_is_ret && !pred_hit) |-> stk_empty); // R7

    AST_RETURN_TOP: assert property (@(posedge clk) disable iff (rst)
        (pred_is_ret && pred_hit) |-> (next_pc == stk_top && pop)); // R6

    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst)
        (push && stk_count < FULL_CNT) |=> stk_count == $past(stk_count) + 1'b1); // R5

    AST_PUSH_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (push && stk_count == FULL_CNT) |=> stk_count == FULL_CNT); // R8

    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        pop |=> stk_count == $past(stk_count) - 1'b1); // R6

    AST_PUSH_POP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(push && pop)); // R5

    AST_STACK_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!push && !pop) |=> $stable(stk_count)); // R10
endmodule

bind fetch_target_predictor ftp_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .fetch_valid (fetch_valid),
    .fetch_pc    (fetch_pc),
    .next_pc     (next_pc),
    .pred_hit    (pred_hit),
    .pred_is_ret (pred_is_ret),
    .push        (do_push),
    .pop         (do_pop),
    .stk_empty   (stk_empty),
    .stk_top     (stk_top),
    .stk_count   (u_stack.count_q)
);

// File: tb/fetch_target_predictor_tb.sv
module fetch_target_predictor_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        fetch_valid;
    logic [31:0] fetch_pc;
    logic        pred_taken;
    logic        upd_valid;
    logic [31:0] upd_pc;
    logic [31:0] upd_target;
    logic [1:0]  upd_kind;
    logic [31:0] next_pc;
    logic        pred_hit;
    logic        pred_is_ret;

    int n_vec  = 0;
    int n_miss = 0;

    // Expected-state model built from the requirements
    logic        m_valid [64];
    logic [1:0]  m_kind  [64];
    logic [7:0]  m_tag   [64];
    logic [31:0] m_tgt   [64];
    logic [31:0] m_stk   [8];
    int          m_tos;
    int          m_cnt;

    always #5 clk = ~clk;

    fetch_target_predictor u_dut (
        .clk         (clk),
        .rst         (rst),
        .fetch_valid (fetch_valid),
        .fetch_pc    (fetch_pc),
        .pred_taken  (pred_taken),
        .upd_valid   (upd_valid),
        .upd_pc      (upd_pc),
        .upd_target  (upd_target),
        .upd_kind    (upd_kind),
        .next_pc     (next_pc),
        .pred_hit    (pred_hit),
        .pred_is_ret (pred_is_ret)
    );

    function automatic logic [31:0] mkpc(input logic [15:0] hi, input logic [7:0] tg,
                                         input logic [5:0] ix);
        return {hi, tg, ix, 2'b00};
    endfunction

    task automatic chk(input string rq, input logic [33:0] act, input logic [33:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_miss++;
            $display("FAIL %s: {next_pc,hit,ret} actual %h expected %h", rq, act, exp);
        end
    endtask

    // Called at a falling edge: drive, check outputs, cross the rising edge, update model.
    task automatic step(input string rq, input logic fv, input logic [31:0] pc,
                        input logic tk, input logic uv, input logic [31:0] upc,
                        input logic [31:0] utgt, input logic [1:0] uk);
        logic [31:0] e_next;
        logic        e_hit, e_ret, e_push, e_pop;
        int          ix;
        fetch_valid = fv; fetch_pc = pc; pred_taken = tk;
        upd_valid = uv; upd_pc = upd_pc; upd_pc = upc; upd_target = utgt; upd_kind = uk;
        #1;
        ix = int'(pc[7:2]);
        e_next = pc + 32'd4; e_hit = 1'b0; e_ret = 1'b0; e_push = 1'b0; e_pop = 1'b0;
        if (fv && m_valid[ix] && m_tag[ix] == pc[15:8]) begin
            if (m_kind[ix] == 2'b10) begin
                e_ret = 1'b1;
                if (m_cnt > 0) begin
                    e_hit = 1'b1; e_next = m_stk[m_tos]; e_pop = 1'b1;
                end
            end else begin
                e_hit = 1'b1;
                if (tk) begin
                    e_next = m_tgt[ix];
                    e_push = (m_kind[ix] == 2'b01);
                end
            end
        end
        chk(rq, {next_pc, pred_hit, pred_is_ret}, {e_next, e_hit, e_ret});
        @(posedge clk);
        if (uv) begin
            m_valid[int'(upc[7:2])] = 1'b1;
            m_kind[int'(upc[7:2])]  = uk;
            m_tag[int'(upc[7:2])]   = upc[15:8];
            m_tgt[int'(upc[7:2])]   = utgt;
        end
        if (e_push) begin
            m_tos = (m_tos + 1) % 8;
            m_stk[m_tos] = pc + 32'd4;
            if (m_cnt < 8) m_cnt++;
        end else if (e_pop) begin
            m_tos = (m_tos + 7) % 8;
            m_cnt--;
        end
        @(negedge clk);
    endtask

    task automatic look(input string rq, input logic [31:0] pc, input logic tk);
        step(rq, 1'b1, pc, tk, 1'b0, 32'h0, 32'h0, 2'b00);
    endtask

    task automatic write(input string rq, input logic [31:0] upc, input logic [31:0] utgt,
                         input logic [1:0] uk);
        step(rq, 1'b0, 32'h0, 1'b0, 1'b1, upc, utgt, uk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_miss++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            m_valid[i] = 1'b0; m_kind[i] = 2'b00; m_tag[i] = 8'h0; m_tgt[i] = 32'h0;
        end
        for (int i = 0; i < 8; i++) m_stk[i] = 32'h0;
        m_tos = 0; m_cnt = 0;
        rst = 1'b1; fetch_valid = 1'b0; fetch_pc = 32'h0; pred_taken = 1'b0;
        upd_valid = 1'b0; upd_pc = 32'h0; upd_target = 32'h0; upd_kind = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: empty after reset, every index misses
        for (int i = 0; i < 64; i++) look("R1", mkpc(16'hA000, 8'(i * 5), 6'(i)), 1'b1);

        // R4 fill (fetch idle also exercises R10); spare kind code on every fourth entry
        for (int i = 0; i < 64; i++)
            write("R10", mkpc(16'h0, 8'(i * 3 + 1), 6'(i)), 32'h4000_0000 + 32'(i * 16),
                  (i % 4 == 3) ? 2'b11 : 2'b00);

        // R3: hits, taken and not taken
        for (int i = 0; i < 64; i++) look("R3", mkpc(16'h0, 8'(i * 3 + 1), 6'(i)), 1'b1);
        for (int i = 0; i < 64; i++) look("R3", mkpc(16'h0, 8'(i * 3 + 1), 6'(i)), 1'b0);

        // R2: upper bits alias, tag mismatch misses
        for (int i = 0; i < 64; i++) look("R2", mkpc(16'hBEEF, 8'(i * 3 + 1), 6'(i)), 1'b1);
        for (int i = 0; i < 64; i++) look("R2", mkpc(16'h0, 8'(i * 3 + 2), 6'(i)), 1'b1);

        // R4: same-cycle write is not seen, next cycle it is
        step("R4", 1'b1, mkpc(16'h0, 8'h07, 6'd5), 1'b1, 1'b1, mkpc(16'h0, 8'h07, 6'd5),
             32'h1234_5670, 2'b00);
        look("R4", mkpc(16'h0, 8'h07, 6'd5), 1'b1);

        // Call entry at index 10, return entry at index 20
        write("R4", mkpc(16'h0, 8'h31, 6'd10), 32'h0000_8000, 2'b01);
        write("R4", mkpc(16'h0, 8'h52, 6'd20), 32'hDEAD_0000, 2'b10);

        // R7: return on empty stack
        look("R7", mkpc(16'h0, 8'h52, 6'd20), 1'b1);

        // R5/R9: three calls, the second with a concurrent table write
        look("R5", mkpc(16'h0100, 8'h31, 6'd10), 1'b1);
        step("R9", 1'b1, mkpc(16'h0101, 8'h31, 6'd10), 1'b1, 1'b1, mkpc(16'h0, 8'h77, 6'd30),
             32'h0ABC_0000, 2'b00);
        look("R9", mkpc(16'h0, 8'h77, 6'd30), 1'b1);
        look("R5", mkpc(16'h0102, 8'h31, 6'd10), 1'b1);
        // R5: not-taken call pushes nothing
        look("R5", mkpc(16'h0199, 8'h31, 6'd10), 1'b0);
        // R10: idle fetch on a return entry does not pop
        step("R10", 1'b0, mkpc(16'h0, 8'h52, 6'd20), 1'b1, 1'b0, 32'h0, 32'h0, 2'b00);

        // R6: pops in LIFO order, direction ignored
        look("R6", mkpc(16'h0, 8'h52, 6'd20), 1'b0);
        look("R6", mkpc(16'h0, 8'h52, 6'd20), 1'b1);
        look("R6", mkpc(16'h0, 8'h52, 6'd20), 1'b1);
        look("R7", mkpc(16'h0, 8'h52, 6'd20), 1'b1);

        // R8: ten pushes, nine pops
        for (int k = 0; k < 10; k++) look("R8", mkpc(16'h0200 + 16'(k), 8'h31, 6'd10), 1'b1);
        for (int k = 0; k < 9; k++) look("R8", mkpc(16'h0, 8'h52, 6'd20), 1'b1);
        look("R7", mkpc(16'h0, 8'h52, 6'd20), 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end
endmodule